// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protect Controller

This block keeps the status state of a 512-byte serial EEPROM and decides, for each requested data write, whether the write may proceed. It receives decoded command strobes from the serial front end: set-latch, clear-latch, write-status, write-data and read-status. It also takes a 9-bit target address, the external write-protect pin and a completion pulse from the write timer. It holds the write-enable latch and the two nonvolatile block-protect bits. It produces a registered status byte, a one-cycle grant pulse for an accepted data write, and a busy flag that stays high for the whole internal write cycle.

The two block-protect bits select a protected region that always ends at the top of the array. The region is empty, the upper quarter, the upper half or the whole array. While an internal write cycle runs, the block ignores every command except read-status, and the status byte reads as all ones. A write-status command that is accepted also starts a timed cycle. The new protect bits take effect when that cycle completes.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear, both protect bits are 0, `busy` is 0, `write_grant` is 0 and `status` is 0x00.
- R2: A set-latch strobe sets the write-enable latch and a clear-latch strobe clears it. This is visible as status bit 1 at the next read-status.
- R3: When idle, a read-status strobe loads `status` with the following bits: bit 0 = 0 (ready), bit 1 = latch, bit 2 = protect bit 0, bit 3 = protect bit 1, bits 7 to 4 = 0.
- R4: A read-status strobe taken while `busy` is 1 loads `status` with 0xFF.
- R5: The protect bits {bit1,bit0} select the protected addresses: 00 none, 01 0x180 to 0x1FF, 10 0x100 to 0x1FF, 11 0x000 to 0x1FF. A write to a protected address is never granted.
- R6: A write-data strobe taken while idle is accepted only when `wp_pin` is 1, the latch is set and the address is unprotected. An accepted write makes `write_grant` pulse for exactly one cycle, and `busy` rises on the same edge.
- R7: A rejected write-data strobe leaves the latch unchanged, gives no grant and does not raise `busy`.
- R8: While `busy` is 1, set-latch, clear-latch, write-status and write-data strobes have no effect on the latch, the protect bits, `busy` or `write_grant`.
- R9: A write-status strobe with the latch set raises `busy` without a grant. The protect bits take the value of `wrsr_bits` when that cycle completes. A write-status strobe with the latch clear is ignored.
- R10: A `cycle_done` pulse while `busy` is 1 clears `busy` and the latch on the same edge. A `cycle_done` pulse while idle has no effect.
- R11: When several strobes arrive in one idle cycle, only one is processed. The order, from highest priority, is clear-latch, set-latch, write-status, write-data.
- R12: `status` changes only on a read-status strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Set-latch strobe |
| cmd_wrdi | input | 1 | Clear-latch strobe |
| cmd_wrsr | input | 1 | Write-status strobe |
| cmd_write | input | 1 | Write-data strobe |
| cmd_rdsr | input | 1 | Read-status strobe |
| wrsr_bits | input | 2 | New protect bits {bit1,bit0} taken with write-status |
| addr | input | 9 | Target address of a write-data strobe |
| wp_pin | input | 1 | Write-protect pin, 1 = writes allowed |
| cycle_done | input | 1 | Write timer completion pulse |
| status | output | 8 | Status byte loaded at the last read-status |
| write_grant | output | 1 | One-cycle pulse for an accepted data write |
| busy | output | 1 | Internal write cycle running |

## Verification
Every result is registered on the clock edge that samples the strobe. The new `status`, the grant pulse and the rise or fall of `busy` are therefore all due exactly one cycle after the strobe is applied, and the grant falls again one cycle later. The bench applies strobes just after a falling edge and steps a behavioural model on each rising edge. It compares all three outputs at the following falling edge, so each result is sampled in the cycle it is due. The directed checks also read the status byte back through read-status to observe the latch and protect bits that the write-status, rejected-write and busy-window cases could have disturbed.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;

    localparam int STAT_W = 8;
    localparam int LVL_W  = 2;

    typedef struct packed {
        logic              wel;
        logic [LVL_W-1:0]  lvl;
        logic              busy;
        logic              sr_pend;
        logic [LVL_W-1:0]  lvl_new;
        logic              grant;
        logic [STAT_W-1:0] stat;
    } ctl_t;

endpackage

// File: rtl/wp_range_dec.sv
module wp_range_dec
    import eeprom_wp_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic [LVL_W-1:0]  level,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] B_NONE = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W:0] B_QTR  = (ADDR_W+1)'(DEPTH - DEPTH/4);
    localparam logic [ADDR_W:0] B_HALF = (ADDR_W+1)'(DEPTH/2);

    logic [ADDR_W:0] lo_bound;

    always_comb begin
        case (level)
            2'b00:   lo_bound = B_NONE;
            2'b01:   lo_bound = B_QTR;
            2'b10:   lo_bound = B_HALF;
            default: lo_bound = '0;
        endcase
        hit = ({1'b0, addr} >= lo_bound);
    end

endmodule

// File: rtl/wp_status_fmt.sv
module wp_status_fmt
    import eeprom_wp_pkg::*;
(
    input  logic              busy,
    input  logic              wel,
    input  logic [LVL_W-1:0]  level,
    output logic [STAT_W-1:0] byte_o
);
    always_comb begin
        if (busy) byte_o = '1;
        else      byte_o = {{(STAT_W-LVL_W-2){1'b0}}, level, wel, 1'b0};
    end

endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
    import eeprom_wp_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_write,
    input  logic              cmd_rdsr,
    input  logic [LVL_W-1:0]  wrsr_bits,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_pin,
    input  logic              cycle_done,
    output logic [STAT_W-1:0] status,
    output logic              write_grant,
    output logic              busy
);
    ctl_t              ctl_d, ctl_q;
    logic              prot_hit;
    logic [STAT_W-1:0] stat_now;

    wp_range_dec #(.ADDR_W(ADDR_W)) u_dec (
        .level (ctl_q.lvl),
        .addr  (addr),
        .hit   (prot_hit)
    );

    wp_status_fmt u_fmt (
        .busy   (ctl_q.busy),
        .wel    (ctl_q.wel),
        .level  (ctl_q.lvl),
        .byte_o (stat_now)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.grant = 1'b0;
        if (cmd_rdsr) ctl_d.stat = stat_now;
        if (ctl_q.busy) begin
            if (cycle_done) begin
                ctl_d.busy = 1'b0;
                ctl_d.wel  = 1'b0;
                if (ctl_q.sr_pend) begin
                    ctl_d.lvl     = ctl_q.lvl_new;
                    ctl_d.sr_pend = 1'b0;
                end
            end
        end else if (cmd_wrdi) begin
            ctl_d.wel = 1'b0;
        end else if (cmd_wren) begin
            ctl_d.wel = 1'b1;
        end else if (cmd_wrsr) begin
            if (ctl_q.wel) begin
                ctl_d.busy    = 1'b1;
                ctl_d.sr_pend = 1'b1;
                ctl_d.lvl_new = wrsr_bits;
            end
        end else if (cmd_write) begin
            if (ctl_q.wel && wp_pin && !prot_hit) begin
                ctl_d.busy  = 1'b1;
                ctl_d.grant = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign status      = ctl_q.stat;
    assign write_grant = ctl_q.grant;
    assign busy        = ctl_q.busy;

    AST_GRANT_OPENS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        write_grant |-> (busy && !$past(busy)));                               // R6
    AST_NO_PROTECTED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && !cmd_wren && !cmd_wrdi && !cmd_wrsr && !ctl_q.busy && prot_hit)
        |=> !write_grant);                                                     // R5
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && cycle_done) |=> (!ctl_q.busy && !ctl_q.wel));           // R10
    AST_LEVEL_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.busy |=> $stable(ctl_q.lvl));                                   // R9
    AST_BUSY_FREEZES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && !cycle_done) |=> (ctl_q.busy && $stable(ctl_q.wel)));   // R8
    AST_STATUS_BUSY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdsr && ctl_q.busy) |=> (status == 8'hFF));                       // R4
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_rdsr |=> $stable(status));                                        // R12

endmodule

// File: tb/sim_eeprom_wp_ctrl.sv
module sim_eeprom_wp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       c_wren = 0, c_wrdi = 0, c_wrsr = 0, c_write = 0, c_rdsr = 0, done = 0;
    logic [1:0] bits = 2'b00;
    logic [8:0] addr = '0;
    logic       pin = 1'b1;
    logic [7:0] status;
    logic       write_grant, busy;

    localparam logic [5:0] M_WREN = 6'd1, M_WRDI = 6'd2, M_WRSR = 6'd4,
                           M_WRITE = 6'd8, M_RDSR = 6'd16, M_DONE = 6'd32;

    int    checks = 0, failures = 0;
    string tag = "R1";

    int m_wel, m_bp, m_busy, m_pend, m_newbp, m_grant, m_stat, lo;

    always #4 clk = ~clk;

    eeprom_wp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wren(c_wren), .cmd_wrdi(c_wrdi),
        .cmd_wrsr(c_wrsr), .cmd_write(c_write), .cmd_rdsr(c_rdsr),
        .wrsr_bits(bits), .addr(addr), .wp_pin(pin), .cycle_done(done),
        .status(status), .write_grant(write_grant), .busy(busy)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wel = 0; m_bp = 0; m_busy = 0; m_pend = 0; m_newbp = 0;
            m_grant = 0; m_stat = 0;
        end else begin
            if (c_rdsr) m_stat = m_busy ? 255 : (m_bp * 4 + m_wel * 2);
            m_grant = 0;
            if (m_bp == 0) lo = 512;
            else if (m_bp == 1) lo = 384;
            else if (m_bp == 2) lo = 256;
            else lo = 0;
            if (m_busy != 0) begin
                if (done) begin
                    m_busy = 0; m_wel = 0;
                    if (m_pend != 0) begin m_bp = m_newbp; m_pend = 0; end
                end
            end else if (c_wrdi) m_wel = 0;
            else if (c_wren) m_wel = 1;
            else if (c_wrsr) begin
                if (m_wel != 0) begin m_busy = 1; m_pend = 1; m_newbp = int'(bits); end
            end else if (c_write) begin
                if (m_wel != 0 && pin && int'(addr) < lo) begin m_busy = 1; m_grant = 1; end
            end
        end
    end

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(tag, int'(status), m_stat);
        chk(tag, int'(write_grant), m_grant);
        chk(tag, int'(busy), m_busy);
    endtask

    task automatic cmd(input logic [5:0] m);
        {done, c_rdsr, c_write, c_wrsr, c_wrdi, c_wren} = m;
        step();
        {done, c_rdsr, c_write, c_wrsr, c_wrdi, c_wren} = '0;
    endtask

    task automatic try_write(input logic [8:0] a, input int exp_g);
        cmd(M_WREN);
        addr = a;
        cmd(M_WRITE);
        chk("R5", int'(write_grant), exp_g);
        if (exp_g != 0) cmd(M_DONE);
        else cmd(M_WRDI);
    endtask

    task automatic set_bp(input logic [1:0] v);
        cmd(M_WREN);
        bits = v;
        cmd(M_WRSR);
        cmd(M_DONE);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1", int'(status), 0);
        chk("R1", int'(busy), 0);
        chk("R1", int'(write_grant), 0);
        rst_n = 1'b1;
        step();

        tag = "R3"; cmd(M_RDSR); chk("R3", int'(status), 8'h00);

        tag = "R7"; addr = 9'h050; cmd(M_WRITE);
        chk("R7", int'(write_grant), 0); chk("R7", int'(busy), 0);

        tag = "R2"; cmd(M_WREN); cmd(M_RDSR); chk("R2", int'(status), 8'h02);
        cmd(M_WRDI); cmd(M_RDSR); chk("R2", int'(status), 8'h00);

        tag = "R6"; cmd(M_WREN); addr = 9'h050; cmd(M_WRITE);
        chk("R6", int'(write_grant), 1); chk("R6", int'(busy), 1);
        step(); chk("R6", int'(write_grant), 0);

        tag = "R4"; cmd(M_RDSR); chk("R4", int'(status), 8'hFF);

        tag = "R8"; bits = 2'b11;
        cmd(M_WRDI); cmd(M_WRSR); cmd(M_WREN); cmd(M_WRITE);
        chk("R8", int'(busy), 1); chk("R8", int'(write_grant), 0);

        tag = "R10"; cmd(M_DONE); chk("R10", int'(busy), 0);
        cmd(M_RDSR); chk("R10", int'(status), 8'h00);
        cmd(M_DONE); chk("R10", int'(busy), 0);
        cmd(M_RDSR); chk("R10", int'(status), 8'h00);

        tag = "R7"; pin = 1'b0; cmd(M_WREN); cmd(M_WRITE);
        chk("R7", int'(write_grant), 0); chk("R7", int'(busy), 0);
        cmd(M_RDSR); chk("R7", int'(status), 8'h02);
        pin = 1'b1;

        tag = "R9"; bits = 2'b01; cmd(M_WRSR);
        chk("R9", int'(busy), 1); chk("R9", int'(write_grant), 0);
        cmd(M_RDSR); chk("R9", int'(status), 8'hFF);
        cmd(M_DONE); cmd(M_RDSR); chk("R9", int'(status), 8'h04);
        cmd(M_WRDI); bits = 2'b11; cmd(M_WRSR); chk("R9", int'(busy), 0);
        cmd(M_RDSR); chk("R9", int'(status), 8'h04);

        tag = "R5";
        try_write(9'h17F, 1); try_write(9'h180, 0); try_write(9'h1FF, 0);
        set_bp(2'b10);
        try_write(9'h0FF, 1); try_write(9'h100, 0);
        set_bp(2'b11);
        try_write(9'h000, 0); try_write(9'h1FF, 0);
        set_bp(2'b00);
        try_write(9'h1FF, 1); try_write(9'h000, 1);

        tag = "R11";
        cmd(M_WREN | M_WRDI); cmd(M_RDSR); chk("R11", int'(status), 8'h00);
        cmd(M_WREN); addr = 9'h010; cmd(M_WREN | M_WRITE);
        chk("R11", int'(write_grant), 0); chk("R11", int'(busy), 0);
        bits = 2'b01; cmd(M_WRSR | M_WRITE);
        chk("R11", int'(busy), 1); chk("R11", int'(write_grant), 0);
        cmd(M_DONE); cmd(M_RDSR); chk("R11", int'(status), 8'h04);

        tag = "R12"; cmd(M_WREN); step(); chk("R12", int'(status), 8'h04);
        cmd(M_RDSR); chk("R12", int'(status), 8'h06);

        tag = "R11";
        for (int i = 0; i < 600; i++) begin
            logic [5:0] m;
            m = 6'($urandom) & 6'($urandom);
            if (busy && ($urandom % 6 == 0)) m[5] = 1'b1;
            addr = 9'($urandom);
            bits = 2'($urandom);
            pin  = ($urandom % 4) != 0;
            cmd(m);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule